// File: doc/BRIEF.md
# Dual-Compare PWM Timer Channel

This block is one channel of a general-purpose timer. A counter advances by one on every enabled count tick and wraps at its top value. Two compare registers, A and B, are compared with the counter on each tick. In normal mode the channel drives nothing: its output-enable is low and its pin output is 0. In PWM mode, a match on A sets the pin output and a match on B clears it. The waveform's rising and falling edges therefore come from two independent register values, not from a period and duty pair.

PWM mode is requested by a per-channel mode bit. A two-bit combined-mode input comes from the timer's shared control. When that input is nonzero, another waveform generator owns the pin and the mode bit is overridden. Software reaches the mode bit and the compare registers through a small synchronous write port with a combinational read-back. The same read port also shows the live counter value.

Top module: `pwm_dual_cmp_chan`

## Requirements
- R1: After synchronous reset, the mode bit, both compare registers and the counter all read 0, and `pin_out`, `pin_oe` and `pwm_active` are 0.
- R2: The counter rises by one on the clock edge that ends each cycle with `cnt_tick` high, wrapping from all-ones to 0. It keeps its value in cycles without a tick.
- R3: `pwm_active` and `pin_oe` are 1 exactly when the stored mode bit is 1 and `combo_mode` is 0.
- R4: A match on A is a cycle with `cnt_tick` high and the counter equal to register A. After a match on A with no match on B, `pin_out` is 1 from the following edge while PWM stays active. Without a match, `pin_out` keeps its level.
- R5: A match on B, defined the same way, makes `pin_out` 0 from the following edge.
- R6: If A and B match in the same tick, `pin_out` becomes 0, because clearing wins.
- R7: In normal mode, `pin_out` and `pin_oe` are 0 and compare matches have no visible effect.
- R8: When PWM becomes active, `pin_out` starts at 0 and stays 0 until the first match on A.
- R9: Any nonzero `combo_mode` (1, 2 or 3) forces `pwm_active`, `pin_oe` and `pin_out` to 0. Reading the mode register still returns the stored bit. When `combo_mode` returns to 0, PWM resumes starting from 0.
- R10: Register map by `reg_addr`: 0 is the mode bit in data bit 0 (other bits read 0), 1 is compare A, 2 is compare B, and 3 is the counter. Address 3 is read-only, and writes to it are ignored. A write with `reg_we` high takes effect on that cycle's closing edge, so a read in the same cycle still shows the old value.
- R11: A write that leaves a compare register equal to the counter value after that edge produces no match at that count. The register next matches only when the counter comes back around to the value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_tick | input | 1 | Count enable; one counter step per cycle it is high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for write and read |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Combinational read data for `reg_addr` |
| combo_mode | input | 2 | Combined-mode field; nonzero overrides the channel's PWM bit |
| pin_out | output | 1 | Channel output level |
| pin_oe | output | 1 | Output-enable for the channel pin |
| pwm_active | output | 1 | Effective PWM mode after the override |

## Verification
The hardest cases to reach are a compare register rewritten to the exact count the counter is sitting on, and both registers matching on the same tick. Both depend on where the counter happens to be when software writes. The bench builds the channel with a 4-bit counter and sweeps every pair of A and B values. Each pair is written while the counter rests at whatever position the previous pair left it, so writes land at many counter positions, including equal values and writes at the current count. The bench tracks the resulting match suppression in its own model of the requirements, and a directed step writes a register at the current count to check R11 on its own.

// File: rtl/pwmc_pkg.sv
// Package: shared register-map encoding for the dual-compare PWM channel.
// Assumes a four-entry map addressed by two bits.
package pwmc_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_MODE = 2'd0,
        ADR_CMPA = 2'd1,
        ADR_CMPB = 2'd2,
        ADR_CNT  = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/pwmc_counter.sv
// Free-running up counter. Steps by one on every tick cycle and wraps
// naturally at 2**CNT_W. Also exposes the value it will hold after the
// coming edge, so that compare units can spot writes equal to the count.
module pwmc_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt
);

    // Next count: advance only on a tick.
    always_comb begin
        cnt_nxt = tick ? cnt_q + CNT_W'(1) : cnt_q;
    end

    // Count register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
    end

endmodule

// File: rtl/pwmc_cmp_unit.sv
// One compare register and its match detector. A match is a tick cycle
// where the counter equals the register. A write that leaves the register
// equal to the post-edge count arms a suppress flag. The flag masks that
// one coincidence and drops on the next tick, so the next match needs a
// full trip around the counter.
module pwmc_cmp_unit #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] cnt_nxt,
    output logic [CNT_W-1:0] cmp_q,
    output logic             hit
);

    logic skip_q;

    // Match detect: equal on a tick and not suppressed by a fresh write.
    always_comb begin
        hit = tick && (cnt_q == cmp_q) && !skip_q;
    end

    // Compare register and suppress flag; a write takes priority over the tick clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            skip_q <= 1'b0;
        end else if (wr) begin
            cmp_q  <= wdata;
            skip_q <= (wdata == cnt_nxt);
        end else if (tick) begin
            skip_q <= 1'b0;
        end
    end

endmodule

// File: rtl/pwmc_wave.sv
// Output stage. Works out the effective PWM mode, with the combined-mode
// override when OVERRIDE_EN is set, and holds the waveform level: clear
// wins over set. The level is forced to 0 whenever PWM is inactive, so
// every entry into PWM starts low.
module pwmc_wave #(
    parameter bit OVERRIDE_EN = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwm_bit,
    input  logic [1:0] combo_mode,
    input  logic       hit_set,
    input  logic       hit_clr,
    output logic       pin_out,
    output logic       pin_oe,
    output logic       pwm_active
);

    logic lvl_q;
    logic eff;

    // Effective mode: the per-channel bit, gated by the override when present.
    generate
        if (OVERRIDE_EN) begin : g_ovr
            always_comb eff = pwm_bit && (combo_mode == 2'd0);
        end else begin : g_plain
            always_comb eff = pwm_bit || (1'b0 && (combo_mode != 2'd0));
        end
    endgenerate

    // Waveform level: zero when inactive, clear beats set, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       lvl_q <= 1'b0;
        else if (!eff)    lvl_q <= 1'b0;
        else if (hit_clr) lvl_q <= 1'b0;
        else if (hit_set) lvl_q <= 1'b1;
    end

    // Pin drive: masked by the mode in the same cycle the mode drops.
    always_comb begin
        pwm_active = eff;
        pin_oe     = eff;
        pin_out    = lvl_q && eff;
    end

endmodule

// File: rtl/pwm_dual_cmp_chan.sv
// Top of the dual-compare PWM channel. Holds the mode bit, decodes register
// writes, instantiates the counter, two compare units (A sets, B clears)
// and the output stage, and muxes read data. Assumes a single clock and
// that reg_addr is stable for combinational reads.
module pwm_dual_cmp_chan #(
    parameter int CNT_W       = 16,
    parameter bit OVERRIDE_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_tick,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic [1:0]       combo_mode,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             pwm_active
);

    import pwmc_pkg::*;

    localparam int N_CMP = 2;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] cmp_val [N_CMP];
    logic [N_CMP-1:0] hit;
    logic             pwm_bit;

    pwmc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (cnt_tick),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt)
    );

    // Compare units: index 0 is A (address 1), index 1 is B (address 2).
    generate
        for (genvar gi = 0; gi < N_CMP; gi++) begin : g_cmp
            localparam logic [ADDR_W-1:0] SEL = ADDR_W'(gi + 1);
            pwmc_cmp_unit #(.CNT_W(CNT_W)) u_unit (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr      (reg_we && (reg_addr == SEL)),
                .wdata   (reg_wdata),
                .tick    (cnt_tick),
                .cnt_q   (cnt_q),
                .cnt_nxt (cnt_nxt),
                .cmp_q   (cmp_val[gi]),
                .hit     (hit[gi])
            );
        end
    endgenerate

    // Mode bit register, written through data bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 pwm_bit <= 1'b0;
        else if (reg_we && (reg_addr == ADR_MODE))  pwm_bit <= reg_wdata[0];
    end

    pwmc_wave #(.OVERRIDE_EN(OVERRIDE_EN)) u_wave (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwm_bit    (pwm_bit),
        .combo_mode (combo_mode),
        .hit_set    (hit[0]),
        .hit_clr    (hit[1]),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe),
        .pwm_active (pwm_active)
    );

    // Read mux over the four map entries.
    always_comb begin
        unique case (reg_addr)
            ADR_MODE: reg_rdata = {{(CNT_W-1){1'b0}}, pwm_bit};
            ADR_CMPA: reg_rdata = cmp_val[0];
            ADR_CMPB: reg_rdata = cmp_val[1];
            default:  reg_rdata = cnt_q;
        endcase
    end

endmodule

// File: rtl/pwmc_chk.sv
// Assertion checker for pwm_dual_cmp_chan, bound to every instance.
// Watches the ports together with the counter, compare and match nets
// that separate submodules drive.
module pwmc_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_tick,
    input logic             reg_we,
    input logic [1:0]       reg_addr,
    input logic [CNT_W-1:0] reg_wdata,
    input logic [1:0]       combo_mode,
    input logic             pwm_bit,
    input logic             pwm_active,
    input logic             pin_out,
    input logic             pin_oe,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] cnt_nxt,
    input logic [CNT_W-1:0] cmp_a,
    input logic             hit_a,
    input logic             hit_b
);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_tick |=> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)));                  // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_tick |=> $stable(cnt_q));                                            // R2
    AST_OE_PWM: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_bit && combo_mode == 2'd0) |-> pin_oe);                              // R3
    AST_SET_A: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_active && hit_a && !hit_b) |=> (!pwm_active || pin_out));            // R4
    AST_HOLD_LVL: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_active && !hit_a && !hit_b) |=> (!pwm_active || pin_out == $past(pin_out))); // R4
    AST_CLR_B: assert property (@(posedge clk) disable iff (!rst_n)
        hit_b |=> !pin_out);                                                      // R5
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_a && hit_b) |=> !pin_out);                                           // R6
    AST_NORMAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_active |-> (!pin_out && !pin_oe));                                   // R7
    AST_ENTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_active) |-> !pin_out);                                          // R8
    AST_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (combo_mode != 2'd0) |-> !pwm_active);                                    // R9
    AST_WR_A: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 2'd1) |=> cmp_a == $past(reg_wdata));              // R10
    AST_EQ_WRITE_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 2'd1 && reg_wdata == cnt_nxt) |=> !hit_a);         // R11

endmodule

bind pwm_dual_cmp_chan pwmc_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_tick   (cnt_tick),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .combo_mode (combo_mode),
    .pwm_bit    (pwm_bit),
    .pwm_active (pwm_active),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .cnt_q      (cnt_q),
    .cnt_nxt    (cnt_nxt),
    .cmp_a      (cmp_val[0]),
    .hit_a      (hit[0]),
    .hit_b      (hit[1])
);

// File: tb/sim_pwm_dual_cmp_chan.sv
// Bench for pwm_dual_cmp_chan, built with a 4-bit counter. It keeps its
// own model of the requirements and checks the outputs after every edge.
module sim_pwm_dual_cmp_chan;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_tick = 1'b0;
    logic         reg_we = 1'b0;
    logic [1:0]   reg_addr = 2'd0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic [1:0]   combo_mode = 2'd0;
    logic         pin_out;
    logic         pin_oe;
    logic         pwm_active;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // Model state, derived from the requirements.
    logic [W-1:0] m_cnt = '0, m_a = '0, m_b = '0;
    logic         m_blka = 1'b0, m_blkb = 1'b0, m_pwm = 1'b0, m_q = 1'b0;

    always #10 clk = ~clk;

    pwm_dual_cmp_chan #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .combo_mode(combo_mode), .pin_out(pin_out), .pin_oe(pin_oe),
        .pwm_active(pwm_active)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] rd_exp(input logic [1:0] ad);
        case (ad)
            2'd0:    return {{(W-1){1'b0}}, m_pwm};
            2'd1:    return m_a;
            2'd2:    return m_b;
            default: return m_cnt;
        endcase
    endfunction

    // One clock cycle: drive at the falling edge, check the same-cycle read,
    // step the model and check the outputs just after the rising edge.
    task automatic cyc(input logic t, input logic we, input logic [1:0] ad,
                       input logic [W-1:0] wd, input string tag);
        logic         eff, ha, hb, q_n, eff_n;
        logic [W-1:0] cnt_n;
        string        ptag;
        @(negedge clk);
        cnt_tick = t; reg_we = we; reg_addr = ad; reg_wdata = wd;
        #1;
        chk("R10 read before edge", int'(reg_rdata), int'(rd_exp(ad)));
        eff   = m_pwm && (combo_mode == 2'd0);
        cnt_n = t ? m_cnt + W'(1) : m_cnt;
        ha    = t && (m_cnt == m_a) && !m_blka;
        hb    = t && (m_cnt == m_b) && !m_blkb;
        q_n   = !eff ? 1'b0 : (hb ? 1'b0 : (ha ? 1'b1 : m_q));
        if (tag != "")      ptag = tag;
        else if (ha && hb)  ptag = "R6";
        else if (hb)        ptag = "R5";
        else if (ha)        ptag = "R4";
        else                ptag = "R4 hold";
        if (we && ad == 2'd1)      begin m_a = wd; m_blka = (wd == cnt_n); end
        else if (t)                m_blka = 1'b0;
        if (we && ad == 2'd2)      begin m_b = wd; m_blkb = (wd == cnt_n); end
        else if (t)                m_blkb = 1'b0;
        if (we && ad == 2'd0)      m_pwm = wd[0];
        m_cnt = cnt_n;
        m_q   = q_n;
        @(posedge clk);
        #1;
        eff_n = m_pwm && (combo_mode == 2'd0);
        chk({ptag, " pin_out"}, int'(pin_out), int'(m_q && eff_n));
        chk("R3 pin_oe", int'(pin_oe), int'(eff_n));
        chk("R3 pwm_active", int'(pwm_active), int'(eff_n));
        chk((ad == 2'd3) ? "R2 count" : "R10 read after edge",
            int'(reg_rdata), int'(rd_exp(ad)));
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 2'd3, '0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 pin_out", int'(pin_out), 0);
        chk("R1 pin_oe", int'(pin_oe), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: every register reads 0 after reset.
        for (int a = 0; a < 4; a++) cyc(1'b0, 1'b0, 2'(a), '0, "R1");

        // R7: normal mode, matches happen but nothing shows.
        cyc(1'b0, 1'b1, 2'd1, W'(3), "R7");
        cyc(1'b0, 1'b1, 2'd2, W'(9), "R7");
        run(20, "R7");

        // R8: enter PWM mid-period; low until the first A match.
        cyc(1'b0, 1'b1, 2'd0, W'(1), "R8");
        run(20, "R8");
        cyc(1'b0, 1'b0, 2'd0, '0, "R3");

        // R9: each nonzero combined mode overrides, then PWM resumes.
        for (int c = 1; c < 4; c++) begin
            combo_mode = 2'(c);
            run(6, "R9");
            cyc(1'b0, 1'b0, 2'd0, '0, "R9");
        end
        combo_mode = 2'd0;
        run(20, "");

        // R10: a write to the counter address is ignored.
        cyc(1'b0, 1'b1, 2'd3, W'(11), "R10");
        cyc(1'b1, 1'b1, 2'd3, W'(5), "R10");

        // R11: write A equal to the resting count; no set at that count until a full wrap.
        cyc(1'b0, 1'b1, 2'd2, m_cnt + W'(8), "R11");
        cyc(1'b0, 1'b1, 2'd1, m_cnt, "R11");
        run(20, "R11");
        // R11 with a tick in the write cycle: value equals the post-edge count.
        cyc(1'b1, 1'b1, 2'd1, m_cnt + W'(1), "R11");
        run(20, "R11");

        // R4/R5/R6/R2: every A,B pair, written wherever the counter rests.
        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                cyc(1'b0, 1'b1, 2'd1, W'(a), "");
                cyc(1'b0, 1'b1, 2'd2, W'(b), "");
                run((1 << W) + 2, "");
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule